// File: doc/BRIEF.md
# Four-Phase Sequential RISC Core

This block is a compact 32-bit processor that carries every instruction through four phases, one clock each: fetch and decode, register read, execute, and write-back. A new instruction is fetched only after the previous one has written back, so no two instructions overlap. The core holds a 128-entry register file and a 10-bit program counter. It talks to an instruction memory, a data memory and a pair of simple input and output ports. Both memories are read combinationally.

Control flow relies mainly on skipping. Any instruction except a jump may ask to skip its successor. The test is one of three conditions: the execute result is zero, the result is negative, or the input port has data waiting. A jump loads the PC from a register and saves the return address. A skip placed in front of a jump therefore gives a conditional branch.

The instruction encoding is specific to this core. Bit 31 set marks a load-constant: bits 30:24 name the destination and bits 23:0 hold a signed immediate. Bit 31 clear marks a register instruction with these fields: class in 30:28, operation in 27:25, rotate in 24:23, skip in 22:21, destination in 20:14, first source A in 13:7, second source B in 6:0.

Top module: `tiny_seq_core`

## Requirements
- R1: Every instruction takes exactly four cycles. The phases run fetch, read, execute, write-back and then fetch again. The PC changes only at the end of write-back, and the output, store and program-write strobes appear only in the write-back cycle.
- R2: While reset is high, the phase returns to fetch, the PC returns to 0 and no strobe is asserted. The first fetch after reset reads address 0.
- R3: The operation codes 0 to 7 compute, in order: A+B, A−B, A+1, A−1, A AND B, A OR B, A XOR B, and A unchanged.
- R4: The rotate field codes 0, 1, 2 and 3 rotate the operation result right by 0, 1, 8 and 16 bits.
- R5: The skip field codes 0 to 3 mean: never skip, skip if the result is zero, skip if the result is negative, and skip if the input valid line is high during execute. When the skip holds, the PC advances by 2. Otherwise it advances by 1.
- R6: Class 6 (jump) loads the PC from the low 10 bits of register A. It writes the address of the jump plus one into the destination, and it never skips.
- R7: A load-constant writes its 24-bit immediate, sign-extended to 32 bits, into the destination.
- R8: Class 2 writes the input data port into the destination. Class 3 writes the data memory word addressed by register B into the destination.
- R9: Class 5 drives a data memory write in write-back, with address = register B and data = register A. It also writes the rotated result into the destination.
- R10: Class 4 presents the rotated result on the output data port with a one-cycle valid pulse in write-back. It also writes the result into the destination.
- R11: Class 1 writes register A into instruction memory at the address in register B during write-back. It also writes the rotated result into the destination.
- R12: A register named both as a source and as the destination supplies its old value.
- R13: Class 0 writes only the rotated result into the destination and drives no strobe. Class 7 behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 10 | Instruction memory address: the PC, or register B during a program write |
| imem_rdata | input | 32 | Instruction word read combinationally |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_wdata | output | 32 | Instruction memory write data |
| dmem_addr | output | 10 | Data memory address (register B) |
| dmem_rdata | input | 32 | Data memory read word |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 32 | Data memory write data (register A) |
| in_data | input | 32 | Input port data |
| in_valid | input | 1 | Input port data available |
| out_data | output | 32 | Output port data |
| out_valid | output | 1 | Output port valid pulse |

## Verification
Some properties are checked on every cycle by assertions. The phase order is one. The PC holds still outside write-back. Outside jumps, the PC moves by exactly one or two. A jump lands on the latched register value. The three strobes are never active together, and a rotation keeps the population count.

Other properties can only be shown by the bench program. The bench checks arithmetic values and rotate amounts. It checks that each skip condition is met or not met as expected, and that the return address is correct. It checks loads from memory and from the input port, and the addresses and data of memory and program writes. These are observed through the output port and the memory strobes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   localparam int INSN_W  = 32;
   localparam int REG_IDX = 7;
   localparam int IMM_W   = 24;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_READ  = 2'd1,
      PH_EXEC  = 2'd2,
      PH_WB    = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      OP_ALU   = 3'd0,
      OP_PWR   = 3'd1,
      OP_LDIN  = 3'd2,
      OP_LDMEM = 3'd3,
      OP_OUT   = 3'd4,
      OP_STMEM = 3'd5,
      OP_JUMP  = 3'd6,
      OP_SPARE = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      FN_ADD = 3'd0,
      FN_SUB = 3'd1,
      FN_INC = 3'd2,
      FN_DEC = 3'd3,
      FN_AND = 3'd4,
      FN_OR  = 3'd5,
      FN_XOR = 3'd6,
      FN_MOV = 3'd7
   } fn_e;

   typedef enum logic [1:0] {
      RT_0  = 2'd0,
      RT_1  = 2'd1,
      RT_8  = 2'd2,
      RT_16 = 2'd3
   } rot_e;

   typedef enum logic [1:0] {
      SK_NEVER = 2'd0,
      SK_ZERO  = 2'd1,
      SK_NEG   = 2'd2,
      SK_INRDY = 2'd3
   } skip_e;

   typedef struct packed {
      logic                 is_const;
      op_e                  op;
      fn_e                  fn;
      rot_e                 rot;
      skip_e                skip;
      logic [REG_IDX-1:0]   dst;
      logic [REG_IDX-1:0]   src_a;
      logic [REG_IDX-1:0]   src_b;
      logic [IMM_W-1:0]     imm;
   } insn_t;

   function automatic insn_t unpack_insn(input logic [INSN_W-1:0] w);
      insn_t d;
      d.is_const = w[31];
      d.imm      = w[23:0];
      d.src_a    = w[13:7];
      d.src_b    = w[6:0];
      if (w[31]) begin
         d.dst  = w[30:24];
         d.op   = OP_ALU;
         d.fn   = FN_MOV;
         d.rot  = RT_0;
         d.skip = SK_NEVER;
      end else begin
         d.dst  = w[20:14];
         d.op   = op_e'(w[30:28]);
         d.fn   = fn_e'(w[27:25]);
         d.rot  = rot_e'(w[24:23]);
         d.skip = skip_e'(w[22:21]);
      end
      return d;
   endfunction

   function automatic int rot_amount(input int code);
      case (code)
         0:       return 0;
         1:       return 1;
         2:       return 8;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/tsc_regfile.sv
module tsc_regfile #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 128,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_a_idx,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [WIDTH-1:0] rd_a,
   output logic [WIDTH-1:0] rd_b,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data
);

   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("tsc_regfile: DEPTH must be a power of two");
      end
   endgenerate

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_a <= cells[rd_a_idx];
         rd_b <= cells[rd_b_idx];
      end
   end

endmodule

// File: rtl/tsc_alu.sv
module tsc_alu
   import tsc_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  fn_e              fn,
   input  rot_e             rot,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] result
);

   localparam int N_ROT = 4;

   generate
      if (WIDTH <= 16) begin : g_bad_width
         $error("tsc_alu: WIDTH must exceed the largest rotate amount");
      end
   endgenerate

   logic [WIDTH-1:0] raw;
   logic [WIDTH-1:0] rotated [N_ROT];

   always_comb begin
      unique case (fn)
         FN_ADD: raw = a + b;
         FN_SUB: raw = a - b;
         FN_INC: raw = a + WIDTH'(1);
         FN_DEC: raw = a - WIDTH'(1);
         FN_AND: raw = a & b;
         FN_OR:  raw = a | b;
         FN_XOR: raw = a ^ b;
         default: raw = a;
      endcase
   end

   for (genvar g = 0; g < N_ROT; g++) begin : g_rot
      localparam int AMT = rot_amount(g);
      if (AMT == 0) begin : g_id
         assign rotated[g] = raw;
      end else begin : g_rr
         assign rotated[g] = {raw[AMT-1:0], raw[WIDTH-1:AMT]};
      end
   end

   assign result = rotated[rot];

   always_comb begin
      if (!$isunknown(raw)) begin
         p_rot_keeps_bits_r4: assert ($countones(result) == $countones(raw))
            else $error("rotation changed the bit population");
      end
   end

endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
   import tsc_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int PC_W  = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  insn_t            insn,
   input  logic [WIDTH-1:0] exec_result,
   input  logic             in_valid,
   input  logic [PC_W-1:0]  jump_target,
   output phase_e           phase,
   output logic [PC_W-1:0]  pc,
   output logic [PC_W-1:0]  pc_next_seq
);

   logic skip_q;
   logic skip_now;
   logic is_jump;

   assign is_jump     = !insn.is_const && insn.op == OP_JUMP;
   assign pc_next_seq = pc + PC_W'(1);

   always_comb begin
      unique case (insn.skip)
         SK_ZERO:  skip_now = exec_result == '0;
         SK_NEG:   skip_now = exec_result[WIDTH-1];
         SK_INRDY: skip_now = in_valid;
         default:  skip_now = 1'b0;
      endcase
      if (is_jump) skip_now = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= PH_FETCH;
         pc     <= '0;
         skip_q <= 1'b0;
      end else begin
         unique case (phase)
            PH_FETCH: phase <= PH_READ;
            PH_READ:  phase <= PH_EXEC;
            PH_EXEC: begin
               phase  <= PH_WB;
               skip_q <= skip_now;
            end
            default: begin
               phase <= PH_FETCH;
               if (is_jump)     pc <= jump_target;
               else if (skip_q) pc <= pc + PC_W'(2);
               else             pc <= pc_next_seq;
            end
         endcase
      end
   end

   p_reset_state_r2: assert property (@(posedge clk)
      rst |=> (pc == '0 && phase == PH_FETCH))
      else $error("reset did not restore fetch at address 0");

   p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
      phase != PH_WB |=> phase == phase_e'($past(phase) + 2'd1))
      else $error("phase sequence broken");

   p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      phase == PH_WB |=> phase == PH_FETCH)
      else $error("write-back not followed by fetch");

   p_pc_hold_r1: assert property (@(posedge clk) disable iff (rst)
      phase != PH_WB |=> $stable(pc))
      else $error("pc moved outside write-back");

   p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_WB && !is_jump) |=>
         (pc == $past(pc) + PC_W'(1) || pc == $past(pc) + PC_W'(2)))
      else $error("sequential pc step out of range");

   p_jump_lands_r6: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_WB && is_jump) |=> pc == $past(jump_target))
      else $error("jump did not reach its target");

endmodule

// File: rtl/tiny_seq_core.sv
module tiny_seq_core
   import tsc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int PC_W     = 10,
   parameter int DADDR_W  = 10,
   parameter int RF_DEPTH = 128
) (
   input  logic               clk,
   input  logic               rst,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [XLEN-1:0]    imem_rdata,
   output logic               imem_we,
   output logic [XLEN-1:0]    imem_wdata,
   output logic [DADDR_W-1:0] dmem_addr,
   input  logic [XLEN-1:0]    dmem_rdata,
   output logic               dmem_we,
   output logic [XLEN-1:0]    dmem_wdata,
   input  logic [XLEN-1:0]    in_data,
   input  logic               in_valid,
   output logic [XLEN-1:0]    out_data,
   output logic               out_valid
);

   localparam int RF_IDX_W = $clog2(RF_DEPTH);

   generate
      if (XLEN != INSN_W) begin : g_bad_xlen
         $error("tiny_seq_core: encoding assumes a 32-bit word");
      end
      if (RF_IDX_W != REG_IDX) begin : g_bad_rf
         $error("tiny_seq_core: encoding assumes 7-bit register indices");
      end
      if (PC_W > XLEN || DADDR_W > XLEN) begin : g_bad_addr
         $error("tiny_seq_core: address wider than the data word");
      end
   endgenerate

   logic [XLEN-1:0] ir;
   insn_t           dec;
   phase_e          phase;
   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] pc_plus1;
   logic [XLEN-1:0] opa;
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] alu_y;
   logic [XLEN-1:0] res_q;
   logic [XLEN-1:0] load_q;
   logic            rf_we;
   logic [XLEN-1:0] rf_wdata;
   logic            in_wb;

   assign dec   = unpack_insn(ir);
   assign in_wb = phase == PH_WB;

   always_ff @(posedge clk) begin
      if (phase == PH_FETCH) ir <= imem_rdata;
   end

   tsc_regfile #(.WIDTH(XLEN), .DEPTH(RF_DEPTH)) u_rf (
      .clk      (clk),
      .rd_en    (phase == PH_READ),
      .rd_a_idx (dec.src_a),
      .rd_b_idx (dec.src_b),
      .rd_a     (opa),
      .rd_b     (opb),
      .wr_en    (rf_we),
      .wr_idx   (dec.dst),
      .wr_data  (rf_wdata)
   );

   tsc_alu #(.WIDTH(XLEN)) u_alu (
      .fn     (dec.fn),
      .rot    (dec.rot),
      .a      (opa),
      .b      (opb),
      .result (alu_y)
   );

   tsc_seq #(.WIDTH(XLEN), .PC_W(PC_W)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .insn        (dec),
      .exec_result (alu_y),
      .in_valid    (in_valid),
      .jump_target (opa[PC_W-1:0]),
      .phase       (phase),
      .pc          (pc),
      .pc_next_seq (pc_plus1)
   );

   always_ff @(posedge clk) begin
      if (phase == PH_EXEC) begin
         res_q  <= alu_y;
         load_q <= (dec.op == OP_LDIN) ? in_data : dmem_rdata;
      end
   end

   always_comb begin
      if (dec.is_const) begin
         rf_wdata = {{(XLEN-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
      end else begin
         unique case (dec.op)
            OP_JUMP:           rf_wdata = {{(XLEN-PC_W){1'b0}}, pc_plus1};
            OP_LDIN, OP_LDMEM: rf_wdata = load_q;
            default:           rf_wdata = res_q;
         endcase
      end
   end

   assign rf_we = in_wb && !rst;

   assign imem_we    = in_wb && !rst && !dec.is_const && dec.op == OP_PWR;
   assign imem_wdata = opa;
   assign imem_addr  = imem_we ? opb[PC_W-1:0] : pc;

   assign dmem_addr  = opb[DADDR_W-1:0];
   assign dmem_wdata = opa;
   assign dmem_we    = in_wb && !rst && !dec.is_const && dec.op == OP_STMEM;

   assign out_data   = res_q;
   assign out_valid  = in_wb && !rst && !dec.is_const && dec.op == OP_OUT;

   p_strobes_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0({imem_we, dmem_we, out_valid}))
      else $error("more than one strobe active");

   p_strobe_phase_r1: assert property (@(posedge clk) disable iff (rst)
      (imem_we || dmem_we || out_valid) |-> $past(phase) == PH_EXEC)
      else $error("strobe outside write-back");

   p_exec_latched_r10: assert property (@(posedge clk) disable iff (rst)
      phase == PH_EXEC |=> res_q == $past(alu_y))
      else $error("execute result not captured");

endmodule

// File: tb/sim_tiny_seq_core.sv
module sim_tiny_seq_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [9:0]  imem_addr;
   logic [31:0] imem_rdata;
   logic        imem_we;
   logic [31:0] imem_wdata;
   logic [9:0]  dmem_addr;
   logic [31:0] dmem_rdata;
   logic        dmem_we;
   logic [31:0] dmem_wdata;
   logic [31:0] in_data = 32'hCAFE_0001;
   logic        in_valid = 1'b0;
   logic [31:0] out_data;
   logic        out_valid;

   always #2 clk = ~clk;

   logic [31:0] imem [1024];
   logic [31:0] dmem [1024];
   assign imem_rdata = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];

   tiny_seq_core u0 (
      .clk(clk), .rst(rst),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .imem_we(imem_we), .imem_wdata(imem_wdata),
      .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
      .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
      .in_data(in_data), .in_valid(in_valid),
      .out_data(out_data), .out_valid(out_valid)
   );

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      if (imem_we) imem[imem_addr] <= imem_wdata;
   end

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic expect_out(input logic [31:0] v, input string req);
      exp_q.push_back(v);
      tag_q.push_back(req);
   endtask

   function automatic logic [31:0] ins(input int op, input int fn, input int rot,
                                       input int sk, input int w, input int a, input int b);
      return {1'b0, op[2:0], fn[2:0], rot[1:0], sk[1:0], w[6:0], a[6:0], b[6:0]};
   endfunction

   function automatic logic [31:0] lc(input int w, input int imm);
      return {1'b1, w[6:0], imm[23:0]};
   endfunction

   // classes: 0 alu 1 prog-write 2 in 3 dmem-load 4 out 5 dmem-store 6 jump
   // ops: 0 add 1 sub 2 inc 3 dec 4 and 5 or 6 xor 7 mov
   initial begin
      for (int i = 0; i < 1024; i++) begin
         imem[i] = 32'h0;
         dmem[i] = 32'h0;
      end
      imem[0]  = lc(1, 5);
      imem[1]  = lc(2, -3);
      imem[2]  = ins(4, 0, 0, 0, 3, 1, 2);
      imem[3]  = ins(4, 1, 0, 0, 4, 1, 2);
      imem[4]  = ins(4, 2, 0, 0, 5, 1, 0);
      imem[5]  = ins(4, 3, 0, 0, 5, 2, 0);
      imem[6]  = ins(4, 4, 0, 0, 6, 1, 2);
      imem[7]  = ins(4, 5, 0, 0, 6, 1, 2);
      imem[8]  = ins(4, 6, 0, 0, 6, 1, 2);
      imem[9]  = lc(7, 32'h123456);
      imem[10] = ins(4, 7, 1, 0, 8, 7, 0);
      imem[11] = ins(4, 7, 2, 0, 8, 7, 0);
      imem[12] = ins(4, 7, 3, 0, 8, 7, 0);
      imem[13] = ins(4, 0, 0, 0, 1, 1, 1);
      imem[14] = ins(4, 7, 0, 0, 9, 1, 0);
      imem[15] = lc(10, 0);
      imem[16] = ins(0, 7, 0, 1, 11, 10, 0);
      imem[17] = ins(4, 7, 0, 0, 9, 1, 0);
      imem[18] = ins(4, 7, 0, 2, 9, 2, 0);
      imem[19] = ins(4, 7, 0, 0, 9, 1, 0);
      imem[20] = ins(4, 7, 0, 1, 9, 7, 0);
      imem[21] = ins(4, 7, 0, 0, 9, 10, 0);
      imem[22] = ins(5, 0, 0, 0, 12, 1, 10);
      imem[23] = ins(3, 7, 0, 0, 13, 0, 10);
      imem[24] = ins(4, 7, 0, 0, 9, 13, 0);
      imem[25] = ins(2, 7, 0, 0, 14, 0, 0);
      imem[26] = ins(4, 7, 0, 0, 9, 14, 0);
      imem[27] = ins(0, 7, 0, 3, 9, 1, 0);
      imem[28] = ins(4, 7, 0, 0, 9, 10, 0);
      imem[29] = lc(15, 40);
      imem[30] = ins(6, 0, 0, 0, 16, 15, 0);
      imem[31] = ins(4, 7, 0, 0, 9, 1, 0);
      imem[40] = ins(4, 7, 0, 0, 9, 16, 0);
      imem[41] = lc(19, 50);
      imem[42] = ins(0, 7, 0, 2, 17, 2, 0);
      imem[43] = ins(6, 0, 0, 0, 18, 19, 0);
      imem[44] = ins(4, 7, 0, 0, 9, 1, 0);
      imem[45] = ins(0, 7, 0, 2, 17, 1, 0);
      imem[46] = ins(6, 0, 0, 0, 18, 19, 0);
      imem[47] = ins(4, 7, 0, 0, 9, 1, 0);
      imem[50] = ins(4, 7, 0, 0, 9, 18, 0);
      imem[51] = lc(21, 60);
      imem[52] = ins(1, 7, 0, 0, 20, 7, 21);
      imem[53] = ins(4, 7, 0, 0, 9, 20, 0);
      imem[54] = ins(0, 7, 0, 3, 9, 1, 0);
      imem[55] = ins(4, 7, 0, 0, 9, 2, 0);
      imem[56] = ins(4, 7, 0, 0, 9, 5, 0);
      imem[57] = lc(22, 57);
      imem[58] = ins(6, 0, 0, 0, 22, 22, 0);
   end

   // driver: expected output stream
   initial begin
      expect_out(32'h0000_0002, "R3 add");
      expect_out(32'h0000_0008, "R3 sub");
      expect_out(32'h0000_0006, "R3 inc");
      expect_out(32'hFFFF_FFFC, "R3 dec");
      expect_out(32'h0000_0005, "R3 and");
      expect_out(32'hFFFF_FFFD, "R3 or / R7 sign extend");
      expect_out(32'hFFFF_FFF8, "R3 xor");
      expect_out(32'h0009_1A2B, "R4 rot1");
      expect_out(32'h5600_1234, "R4 rot8");
      expect_out(32'h3456_0012, "R4 rot16");
      expect_out(32'h0000_000A, "R12 same src/dst");
      expect_out(32'h0000_000A, "R10 dst also written");
      expect_out(32'hFFFF_FFFD, "R5 zero-skip taken / R13");
      expect_out(32'h0012_3456, "R5 neg-skip taken, zero-skip not taken");
      expect_out(32'h0000_0000, "R5 no spurious skip");
      expect_out(32'h0000_000A, "R8 load from data memory");
      expect_out(32'hCAFE_0001, "R8 load from input");
      expect_out(32'h0000_0000, "R5 input-skip not taken");
      expect_out(32'h0000_001F, "R6 return address");
      expect_out(32'h0000_000A, "R6 skip over jump");
      expect_out(32'h0000_002F, "R6 conditional jump taken");
      expect_out(32'h0012_3456, "R11 destination of program write");
      expect_out(32'hFFFF_FFFC, "R5 input-skip taken");
   end

   // monitor
   always @(negedge clk) begin
      if (rst) begin
         check("R2 no strobe in reset", {29'h0, out_valid, dmem_we, imem_we}, 32'h0);
      end else begin
         if (cyc == 0) check("R2 first fetch address", {22'h0, imem_addr}, 32'h0);
         if (cyc % 4 == 0 && imem_addr == 10'd54) in_valid = 1'b1;
         if (out_valid) begin
            check("R1 output in write-back cycle", cyc % 4, 3);
            if (exp_q.size() == 0) begin
               check("R10 unexpected output", out_data, 32'hDEAD_BEEF);
            end else begin
               check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
         end
         if (dmem_we) begin
            check("R9 store address", {22'h0, dmem_addr}, 32'h0);
            check("R9 store data", dmem_wdata, 32'h0000_000A);
         end
         if (imem_we) begin
            check("R11 program write address", {22'h0, imem_addr}, 32'd60);
            check("R11 program write data", imem_wdata, 32'h0012_3456);
         end
         cyc++;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      fork
         begin
            wait (cyc >= 400);
            check("R1 all outputs produced", exp_q.size(), 0);
            check("R11 memory updated", imem[60], 32'h0012_3456);
            check("R9 memory updated", dmem[0], 32'h0000_000A);
         end
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=400", cyc);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule